// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block governs how a CAN node leaves the bus when its transmit error count overflows, and how it returns. A one-cycle pulse from the error-counting logic marks the overflow. The sequencer then raises its bus-off status and forces the initialization bit high on its own. While that bit is high, bus activity is held off. The CPU may set or clear the initialization bit at any time through two write strobes.

Recovery starts only after the CPU clears initialization while the node is bus-off. From then on, the block watches a per-bit sample strobe together with the received bus level. It counts runs of consecutive recessive bits, and each completed run marks one bus-idle period. Each completed run advances a sequence counter, which stands in for the receive error counter field, and loads the Bit0 code into the last-error-code field. When the required number of runs has been seen, the block pulses a clear to the error counters, drops bus-off and emits a recovered pulse. Writes to the initialization bit can pause this wait but never shorten it.

Top module: `can_busoff_recovery`

## Requirements
- R1: After reset, `bus_off_o`, `init_o`, `lec_o`, `rec_seq_o`, `recovered_o` and `err_clr_o` are all zero, and `bus_active_o` is one.
- R2: A `busoff_evt_i` pulse while not bus-off sets `bus_off_o` and `init_o` on the next cycle, clears `rec_seq_o` to 0, and drives `bus_active_o` low. `bus_active_o` is high only when both `init_o` and `bus_off_o` are low.
- R3: Bits are counted only while `bus_off_o` is 1 and `init_o` is 0. Recessive strobes at any other time leave `rec_seq_o` unchanged.
- R4: While counting, each run of `RUN_LEN` (default 11) consecutive recessive strobed bits (`rx_bit_i`=1) increments `rec_seq_o` by one and loads `lec_o` with the Bit0 code 3'd5.
- R5: A dominant strobed bit (`rx_bit_i`=0) during the wait restarts the current run at zero. Runs already counted in `rec_seq_o` are kept.
- R6: Setting `init_o` during the wait pauses counting and keeps both the partial run and `rec_seq_o`. After init is cleared, counting resumes from where it stopped and never skips ahead.
- R7: On the strobe that completes run number `IDLE_RUNS` (default 129), the next cycle shows `bus_off_o`=0, `rec_seq_o`=0 and `init_o`=0, with `recovered_o` and `err_clr_o` both high for exactly that one cycle.
- R8: A `busoff_evt_i` pulse while already bus-off is ignored: `rec_seq_o`, `init_o` and `bus_off_o` keep their values.
- R9: `init_set_i` sets `init_o` and `init_clr_i` clears it on the next cycle. If both are asserted in the same cycle, set wins.
- R10: The bus level is ignored on cycles without `bit_strobe_i`. Without a strobe, `rec_seq_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busoff_evt_i | input | 1 | One-cycle pulse: transmit error count went above 255 |
| bit_strobe_i | input | 1 | One-cycle pulse at each bit sample point |
| rx_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| init_set_i | input | 1 | CPU write setting the initialization bit |
| init_clr_i | input | 1 | CPU write clearing the initialization bit |
| init_o | output | 1 | Initialization bit |
| bus_off_o | output | 1 | High from bus-off entry until recovery completes |
| bus_active_o | output | 1 | Node may take part in bus traffic |
| lec_o | output | 3 | Last error code (5 = Bit0) |
| rec_seq_o | output | CNT_W | Completed idle-run count during recovery |
| err_clr_o | output | 1 | One-cycle pulse resetting the transmit and receive error counters |
| recovered_o | output | 1 | One-cycle pulse at the end of recovery |

## Verification
The bench builds the block with its default values: runs of 11 bits, 129 runs and an 8-bit counter. The full recovery of 1419 recessive bits therefore fits comfortably in the cycle budget. This lets the exact boundary be checked, namely counter value 128 with one bit missing, then the single completing strobe. Partial runs interrupted by dominant bits, by an init pause and by strobe-free cycles are placed at both the start and the middle of the wait.

// File: rtl/can_bo_pkg.sv
package can_bo_pkg;

    typedef enum logic [2:0] {
        LEC_NONE  = 3'd0,
        LEC_STUFF = 3'd1,
        LEC_FORM  = 3'd2,
        LEC_ACK   = 3'd3,
        LEC_BIT1  = 3'd4,
        LEC_BIT0  = 3'd5,
        LEC_CRC   = 3'd6,
        LEC_NOCHG = 3'd7
    } lec_e;

endpackage

// File: rtl/bo_run_det.sv
module bo_run_det #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic rx_rec_i,
    output logic done_o
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    logic [RUN_W-1:0] cnt_d, cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == RUN_W'(RUN_LEN - 1));
    assign done_o = en_i && rx_rec_i && at_end;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            if (!rx_rec_i || at_end) cnt_d = '0;
            else                     cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/bo_seq_cnt.sv
module bo_seq_cnt #(
    parameter int RUNS  = 129,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign last_o  = inc_i && (cnt_q == CNT_W'(RUNS - 1));
    assign count_o = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || last_o) cnt_d = '0;
        else if (inc_i)      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery
    import can_bo_pkg::*;
#(
    parameter int RUN_LEN   = 11,
    parameter int IDLE_RUNS = 129,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busoff_evt_i,
    input  logic             bit_strobe_i,
    input  logic             rx_bit_i,
    input  logic             init_set_i,
    input  logic             init_clr_i,
    output logic             init_o,
    output logic             bus_off_o,
    output logic             bus_active_o,
    output logic [2:0]       lec_o,
    output logic [CNT_W-1:0] rec_seq_o,
    output logic             err_clr_o,
    output logic             recovered_o
);
    typedef struct packed {
        logic bus_off;
        logic init;
        lec_e lec;
        logic recovered;
        logic err_clr;
    } state_t;

    state_t st_d, st_q;

    logic entry;
    logic count_en;
    logic run_done;
    logic seq_last;

    assign entry    = busoff_evt_i && !st_q.bus_off;
    assign count_en = st_q.bus_off && !st_q.init && bit_strobe_i;

    bo_run_det #(.RUN_LEN(RUN_LEN)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (entry),
        .en_i    (count_en),
        .rx_rec_i(rx_bit_i),
        .done_o  (run_done)
    );

    bo_seq_cnt #(.RUNS(IDLE_RUNS), .CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (entry),
        .inc_i  (run_done),
        .count_o(rec_seq_o),
        .last_o (seq_last)
    );

    always_comb begin
        st_d           = st_q;
        st_d.recovered = 1'b0;
        st_d.err_clr   = 1'b0;
        if (init_set_i)      st_d.init = 1'b1;
        else if (init_clr_i) st_d.init = 1'b0;
        if (entry) begin
            st_d.bus_off = 1'b1;
            st_d.init    = 1'b1;
        end
        if (run_done) st_d.lec = LEC_BIT0;
        if (seq_last) begin
            st_d.bus_off   = 1'b0;
            st_d.recovered = 1'b1;
            st_d.err_clr   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bus_off   <= 1'b0;
            st_q.init      <= 1'b0;
            st_q.lec       <= LEC_NONE;
            st_q.recovered <= 1'b0;
            st_q.err_clr   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign init_o       = st_q.init;
    assign bus_off_o    = st_q.bus_off;
    assign bus_active_o = !st_q.init && !st_q.bus_off;
    assign lec_o        = st_q.lec;
    assign err_clr_o    = st_q.err_clr;
    assign recovered_o  = st_q.recovered;

endmodule

// File: rtl/can_busoff_recovery_chk.sv
module can_busoff_recovery_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busoff_evt_i,
    input logic             bit_strobe_i,
    input logic             init_set_i,
    input logic             init_clr_i,
    input logic             init_o,
    input logic             bus_off_o,
    input logic             bus_active_o,
    input logic [2:0]       lec_o,
    input logic [CNT_W-1:0] rec_seq_o,
    input logic             err_clr_o,
    input logic             recovered_o
);
    assert_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff_evt_i && !bus_off_o) |=> (bus_off_o && init_o && !bus_active_o));

    assert_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active_o |-> (!init_o && !bus_off_o));

    assert_hold_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off_o && init_o && !busoff_evt_i) |=> $stable(rec_seq_o));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off_o && !$stable(rec_seq_o)) |->
            (rec_seq_o == $past(rec_seq_o) + 1'b1 && lec_o == 3'd5));

    assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recovered_o |-> (err_clr_o && !bus_off_o && rec_seq_o == '0));

    assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recovered_o |=> !recovered_o);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_set_i |=> init_o);

    assert_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_strobe_i && !busoff_evt_i) |=> $stable(rec_seq_o));

endmodule

bind can_busoff_recovery can_busoff_recovery_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busoff_evt_i(busoff_evt_i),
    .bit_strobe_i(bit_strobe_i),
    .init_set_i  (init_set_i),
    .init_clr_i  (init_clr_i),
    .init_o      (init_o),
    .bus_off_o   (bus_off_o),
    .bus_active_o(bus_active_o),
    .lec_o       (lec_o),
    .rec_seq_o   (rec_seq_o),
    .err_clr_o   (err_clr_o),
    .recovered_o (recovered_o)
);

// File: tb/tb_can_busoff_recovery.sv
module tb_can_busoff_recovery;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busoff_evt_i = 1'b0, bit_strobe_i = 1'b0, rx_bit_i = 1'b1;
    logic init_set_i = 1'b0, init_clr_i = 1'b0;
    logic init_o, bus_off_o, bus_active_o, err_clr_o, recovered_o;
    logic [2:0] lec_o;
    logic [CNT_W-1:0] rec_seq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    can_busoff_recovery dut (
        .clk(clk), .rst_n(rst_n), .busoff_evt_i(busoff_evt_i),
        .bit_strobe_i(bit_strobe_i), .rx_bit_i(rx_bit_i),
        .init_set_i(init_set_i), .init_clr_i(init_clr_i),
        .init_o(init_o), .bus_off_o(bus_off_o), .bus_active_o(bus_active_o),
        .lec_o(lec_o), .rec_seq_o(rec_seq_o), .err_clr_o(err_clr_o),
        .recovered_o(recovered_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bits(input logic lvl, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_bit_i = lvl; bit_strobe_i = 1'b1;
            @(negedge clk); bit_strobe_i = 1'b0;
        end
    endtask

    task automatic pulse_evt();
        @(negedge clk); busoff_evt_i = 1'b1;
        @(negedge clk); busoff_evt_i = 1'b0;
    endtask

    task automatic cpu_write(input logic s, input logic c);
        @(negedge clk); init_set_i = s; init_clr_i = c;
        @(negedge clk); init_set_i = 1'b0; init_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "bus_off", bus_off_o, 0);
        chk("R1", "init", init_o, 0);
        chk("R1", "lec", lec_o, 0);
        chk("R1", "seq", rec_seq_o, 0);
        chk("R1", "pulses", {recovered_o, err_clr_o}, 0);
        chk("R1", "active", bus_active_o, 1);
    endtask

    task automatic t_init_writes();
        cpu_write(1'b1, 1'b0); chk("R9", "set", init_o, 1);
        cpu_write(1'b0, 1'b1); chk("R9", "clear", init_o, 0);
        cpu_write(1'b1, 1'b1); chk("R9", "both set wins", init_o, 1);
        cpu_write(1'b0, 1'b1); chk("R9", "clear again", init_o, 0);
    endtask

    task automatic t_idle_no_count();
        bits(1'b1, 25);
        chk("R3", "no count outside bus-off", rec_seq_o, 0);
    endtask

    task automatic t_enter();
        pulse_evt();
        chk("R2", "bus_off", bus_off_o, 1);
        chk("R2", "init", init_o, 1);
        chk("R2", "active low", bus_active_o, 0);
        chk("R2", "seq cleared", rec_seq_o, 0);
    endtask

    task automatic t_hold_init();
        bits(1'b1, 30);
        chk("R3", "no count while init", rec_seq_o, 0);
    endtask

    task automatic t_dominant();
        cpu_write(1'b0, 1'b1);
        bits(1'b1, 10); chk("R5", "partial run", rec_seq_o, 0);
        bits(1'b0, 1);
        bits(1'b1, 10); chk("R5", "run restarted", rec_seq_o, 0);
        bits(1'b1, 1);
        chk("R4", "first run", rec_seq_o, 1);
        chk("R4", "lec bit0", lec_o, 5);
        bits(1'b1, 3); bits(1'b0, 1);
        chk("R5", "completed runs kept", rec_seq_o, 1);
    endtask

    task automatic t_no_strobe();
        @(negedge clk); rx_bit_i = 1'b1;
        repeat (30) @(negedge clk);
        chk("R10", "no strobe no count", rec_seq_o, 1);
    endtask

    task automatic t_pause();
        bits(1'b1, 5);
        cpu_write(1'b1, 1'b0);
        bits(1'b1, 20);
        chk("R6", "paused", rec_seq_o, 1);
        cpu_write(1'b0, 1'b1);
        bits(1'b1, 5);
        chk("R6", "resumed no skip", rec_seq_o, 1);
        bits(1'b1, 1);
        chk("R6", "resumed run done", rec_seq_o, 2);
    endtask

    task automatic t_reentry();
        pulse_evt();
        chk("R8", "seq kept", rec_seq_o, 2);
        chk("R8", "init kept", init_o, 0);
        chk("R8", "bus_off kept", bus_off_o, 1);
    endtask

    task automatic t_complete();
        bits(1'b1, 126 * 11);
        chk("R4", "128 runs", rec_seq_o, 128);
        bits(1'b1, 10);
        chk("R7", "one bit short", bus_off_o, 1);
        chk("R7", "no early pulse", recovered_o, 0);
        @(negedge clk); rx_bit_i = 1'b1; bit_strobe_i = 1'b1;
        @(negedge clk); bit_strobe_i = 1'b0;
        chk("R7", "recovered pulse", recovered_o, 1);
        chk("R7", "err clear pulse", err_clr_o, 1);
        chk("R7", "bus_off low", bus_off_o, 0);
        chk("R7", "seq zero", rec_seq_o, 0);
        chk("R7", "init low", init_o, 0);
        @(negedge clk);
        chk("R7", "pulse ends", {recovered_o, err_clr_o}, 0);
        chk("R2", "active after recovery", bus_active_o, 1);
    endtask

    task automatic t_second_entry();
        pulse_evt();
        chk("R2", "second entry", {bus_off_o, init_o}, 3);
        chk("R2", "second entry seq", rec_seq_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_writes();
        t_idle_no_count();
        t_enter();
        t_hold_init();
        t_dominant();
        t_no_strobe();
        t_pause();
        t_reentry();
        t_complete();
        t_second_entry();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule